// File: doc/BRIEF.md
# Digital Potentiometer Serial Command Interface

This block is the serial slave front end and register store of a single-channel digital potentiometer. A host frames each command with an active-low chip select, clocks bytes in on a serial data line (mode 0, most significant bit first), and reads replies on a serial data output. The output has a separate enable, so the line can be released whenever the device is not answering. The wiper setting leaves the block as a parallel word for the resistor array. Four stored data registers model the nonvolatile presets. Each is a plain flop, paired with a programming timer.

Each frame opens with a header byte and then a command byte. The header byte carries a fixed device-type nibble, an address bit that must match the strap pin, and a read/write flag. The command byte carries an opcode and a two-bit register pointer. Reads and writes of the wiper or of a data register, and status reads, take four bytes: header, command, a filler byte, and a data byte. The two register-to-register moves take only the header and command bytes. Writes into the stored registers take effect only when chip select rises after a complete frame. Each such write starts a busy period, which a status read can poll.

All pins are brought into the clock domain through synchronizers. The serial clock must therefore run well below the system clock.

Top module: `dpot_serial_if`

## Requirements
- R1: After reset the wiper output, all four data registers and the busy flag are zero, and the serial output enable is low.
- R2: A header byte is accepted only if bits 7:4 are 0101, bits 3:2 are 00, and bit 1 equals addr_i. Otherwise the frame is dropped: the output enable stays low and no register changes.
- R3: Command byte layout is opcode in bits 7:5, pointer in bits 3:2 (00..11 selecting data register 0..3), and zero in bits 4, 1 and 0. Opcodes: 100 read wiper, 101 write wiper, 110 read data register, 111 write data register, 010 read status, 011 data register to wiper, 001 wiper to data register. Opcode 000 or a nonzero reserved bit drops the frame.
- R4: Header bit 0 is 1 for the three read opcodes and 0 for all others. A mismatch drops the frame.
- R5: Write wiper loads the low WW bits of the fourth byte into wiper_o once that byte is complete.
- R6: For a read, the output enable rises on the falling serial clock after the third byte. The fourth byte then carries the value, most significant bit first, zero-extended to 8 bits, and each bit changes on a falling edge. The enable drops when chip select rises.
- R7: Write data register stores the low WW bits of the fourth byte in the pointed register only when chip select rises, and this sets the busy flag.
- R8: On chip select rise after two bytes, data register to wiper copies the pointed register to wiper_o. Wiper to data register copies wiper_o into the pointed register and sets the busy flag.
- R9: The busy flag stays set for PROG_CYCLES clock cycles and then clears. Read status returns 0000000 followed by the busy flag.
- R10: While busy, every frame other than read status is dropped.
- R11: A frame that ends before its required byte count has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data in |
| addr_i | input | 1 | Address strap compared with header bit 1 |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| wiper_o | output | WW | Current wiper setting |

## Verification
The assertions assume a single host that keeps chip select high between frames for several clock cycles. They also assume that no frame overlaps a commit, so a busy period can begin only while chip select is high. The checks on the wiper and on the enable depend on the serial clock staying much slower than the synchronizer latency. The stimulus holds every serial clock phase for eight system clocks and leaves sixteen idle cycles after each frame. It keeps the address strap static throughout.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'b000,
    OP_WCR2DR = 3'b001,
    OP_RDSR   = 3'b010,
    OP_DR2WCR = 3'b011,
    OP_RDWCR  = 3'b100,
    OP_WRWCR  = 3'b101,
    OP_RDDR   = 3'b110,
    OP_WRDR   = 3'b111
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_LIVE} st_e;

  localparam logic [3:0] DEV_TYPE = 4'b0101;
  localparam int unsigned NUM_DR  = 4;

  function automatic logic is_read(op_e op);
    return (op == OP_RDWCR) || (op == OP_RDDR) || (op == OP_RDSR);
  endfunction

  function automatic logic [2:0] frame_len(op_e op);
    return ((op == OP_WCR2DR) || (op == OP_DR2WCR)) ? 3'd2 : 3'd4;
  endfunction
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
  parameter int unsigned W       = 3,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {STAGES{RST_VAL[b]}};
      else         ff <= {ff[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = ff[STAGES-1];
  end
endmodule

// File: rtl/dpot_shift.sv
module dpot_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_n_i,
  input  logic       sck_i,
  input  logic       sdi_i,
  output logic       frm_start_o,
  output logic       frm_end_o,
  output logic       sck_fall_o,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic [2:0] byte_idx_o,
  output logic [2:0] byte_cnt_o
);
  logic       cs_d, sck_d, sck_rise;
  logic [2:0] bit_cnt;
  logic [6:0] sh_q;

  assign frm_start_o = cs_d & ~cs_n_i;
  assign frm_end_o   = ~cs_d & cs_n_i;
  assign sck_rise    = ~sck_d & sck_i & ~cs_n_i;
  assign sck_fall_o  = sck_d & ~sck_i & ~cs_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d       <= 1'b1;
      sck_d      <= 1'b0;
      bit_cnt    <= '0;
      sh_q       <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      byte_idx_o <= '0;
      byte_cnt_o <= '0;
    end else begin
      cs_d       <= cs_n_i;
      sck_d      <= sck_i;
      byte_vld_o <= 1'b0;
      if (frm_start_o) begin
        bit_cnt    <= '0;
        sh_q       <= '0;
        byte_cnt_o <= '0;
      end else if (sck_rise) begin
        sh_q    <= {sh_q[5:0], sdi_i};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {sh_q, sdi_i};
          byte_idx_o <= byte_cnt_o;
          if (byte_cnt_o != 3'd7) byte_cnt_o <= byte_cnt_o + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs #(
  parameter int unsigned WW          = 7,
  parameter int unsigned PROG_CYCLES = 2000,
  parameter int unsigned NDR         = 4,
  localparam int unsigned PW = $clog2(NDR),
  localparam int unsigned TW = $clog2(PROG_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wcr_we_i,
  input  logic [WW-1:0] wcr_d_i,
  input  logic          dr_we_i,
  input  logic [PW-1:0] sel_i,
  input  logic [WW-1:0] dr_d_i,
  output logic [WW-1:0] wcr_o,
  output logic [WW-1:0] dr_rd_o,
  output logic          wip_o
);
  logic [WW-1:0] dr_q [NDR];
  logic [TW-1:0] tmr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wcr_o <= '0;
    else if (wcr_we_i) wcr_o <= wcr_d_i;
  end

  for (genvar g = 0; g < NDR; g++) begin : g_dr
    logic [WW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= '0;
      else if (dr_we_i && sel_i == PW'(g))     q <= dr_d_i;
    end
    assign dr_q[g] = q;
  end

  // programming timer: nonvolatile write modeled as a fixed busy window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           tmr_q <= '0;
    else if (dr_we_i)      tmr_q <= TW'(PROG_CYCLES);
    else if (tmr_q != '0)  tmr_q <= tmr_q - TW'(1);
  end

  assign wip_o   = (tmr_q != '0);
  assign dr_rd_o = dr_q[sel_i];
endmodule

// File: rtl/dpot_tx.sv
module dpot_tx (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       fall_i,
  output logic       sdo_o,
  output logic       oe_o
);
  logic [7:0] tx_q;
  logic       armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q    <= '0;
      armed_q <= 1'b0;
      oe_o    <= 1'b0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      oe_o    <= 1'b0;
    end else if (load_i) begin
      tx_q    <= data_i;
      armed_q <= 1'b1;
      oe_o    <= 1'b0;
    end else if (fall_i && armed_q) begin
      // first falling edge presents MSB, later ones shift
      if (!oe_o) oe_o <= 1'b1;
      else       tx_q <= {tx_q[6:0], 1'b0};
    end
  end

  assign sdo_o = oe_o & tx_q[7];
endmodule

// File: rtl/dpot_serial_if.sv
module dpot_serial_if
  import dpot_pkg::*;
#(
  parameter int unsigned WW          = 7,
  parameter int unsigned PROG_CYCLES = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sck_i,
  input  logic          sdi_i,
  input  logic          addr_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [WW-1:0] wiper_o
);
  localparam int unsigned PW = $clog2(NUM_DR);

  logic cs_s, sck_s, sdi_s;
  logic frm_start, frm_end, sck_fall, byte_vld;
  logic [7:0] byte_q;
  logic [2:0] byte_idx, byte_cnt;

  st_e           st_q;
  op_e           op_q, op_in;
  logic          rw_q;
  logic [PW-1:0] ptr_q;
  logic [WW-1:0] data_q;

  logic          wcr_we, dr_we, wip, tx_load;
  logic [WW-1:0] wcr_d, dr_d, dr_rd;
  logic [7:0]    tx_data;
  logic          id_ok, cmd_ok;

  dpot_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i({cs_ni, sck_i, sdi_i}),
    .q_o({cs_s, sck_s, sdi_s})
  );

  dpot_shift u_shift (
    .clk_i, .rst_ni,
    .cs_n_i(cs_s), .sck_i(sck_s), .sdi_i(sdi_s),
    .frm_start_o(frm_start), .frm_end_o(frm_end), .sck_fall_o(sck_fall),
    .byte_vld_o(byte_vld), .byte_o(byte_q),
    .byte_idx_o(byte_idx), .byte_cnt_o(byte_cnt)
  );

  dpot_regs #(.WW(WW), .PROG_CYCLES(PROG_CYCLES), .NDR(NUM_DR)) u_regs (
    .clk_i, .rst_ni,
    .wcr_we_i(wcr_we), .wcr_d_i(wcr_d),
    .dr_we_i(dr_we), .sel_i(ptr_q), .dr_d_i(dr_d),
    .wcr_o(wiper_o), .dr_rd_o(dr_rd), .wip_o(wip)
  );

  dpot_tx u_tx (
    .clk_i, .rst_ni,
    .clr_i(frm_start | frm_end),
    .load_i(tx_load), .data_i(tx_data), .fall_i(sck_fall),
    .sdo_o, .oe_o(sdo_oe_o)
  );

  assign op_in  = op_e'(byte_q[7:5]);
  assign id_ok  = (byte_q[7:4] == DEV_TYPE) && (byte_q[3:2] == 2'b00) && (byte_q[1] == addr_i);
  assign cmd_ok = !byte_q[4] && (byte_q[1:0] == 2'b00) && (op_in != OP_NONE)
                  && (is_read(op_in) == rw_q) && (!wip || op_in == OP_RDSR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_NONE;
      rw_q   <= 1'b0;
      ptr_q  <= '0;
      data_q <= '0;
    end else if (frm_start) begin
      st_q <= ST_HDR;
    end else if (frm_end) begin
      st_q <= ST_IDLE;
    end else if (byte_vld) begin
      unique case (byte_idx)
        3'd0: if (st_q == ST_HDR) begin
          if (id_ok) rw_q <= byte_q[0];
          else       st_q <= ST_IDLE;
        end
        3'd1: if (st_q == ST_HDR) begin
          if (cmd_ok) begin
            st_q  <= ST_LIVE;
            op_q  <= op_in;
            ptr_q <= byte_q[3:2];
          end else begin
            st_q <= ST_IDLE;
          end
        end
        3'd3: if (st_q == ST_LIVE && op_q == OP_WRDR) data_q <= byte_q[WW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    wcr_we = 1'b0;
    wcr_d  = byte_q[WW-1:0];
    dr_we  = 1'b0;
    dr_d   = data_q;
    if (byte_vld && st_q == ST_LIVE && byte_idx == 3'd3 && op_q == OP_WRWCR)
      wcr_we = 1'b1;
    if (frm_end && st_q == ST_LIVE && byte_cnt >= frame_len(op_q)) begin
      unique case (op_q)
        OP_WRDR:   dr_we = 1'b1;
        OP_WCR2DR: begin dr_we = 1'b1; dr_d = wiper_o; end
        OP_DR2WCR: begin wcr_we = 1'b1; wcr_d = dr_rd; end
        default: ;
      endcase
    end
  end

  always_comb begin
    tx_data = '0;
    unique case (op_q)
      OP_RDWCR: tx_data[WW-1:0] = wiper_o;
      OP_RDDR:  tx_data[WW-1:0] = dr_rd;
      default:  tx_data[0]      = wip;
    endcase
  end

  assign tx_load = byte_vld && st_q == ST_LIVE && byte_idx == 3'd2 && is_read(op_q);
endmodule

// File: rtl/dpot_serial_if_chk.sv
module dpot_serial_if_chk #(
  parameter int unsigned WW          = 7,
  parameter int unsigned PROG_CYCLES = 2000
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          sdo_oe_o,
  input logic [WW-1:0] wiper_o,
  input logic          wip_i
);
  localparam int unsigned CW = $clog2(PROG_CYCLES + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (!wip_i) run_q <= '0;
    else             run_q <= run_q + CW'(1);
  end

  a_r6_oe_inside_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> !cs_ni);

  a_r6_oe_off_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3)) |-> !sdo_oe_o);

  a_r7_busy_after_cs_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> cs_ni);

  a_r9_busy_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= CW'(PROG_CYCLES));

  a_r10_wiper_frozen_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wiper_o) |-> !$past(wip_i));
endmodule

bind dpot_serial_if dpot_serial_if_chk #(.WW(WW), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni),
  .sdo_oe_o(sdo_oe_o), .wiper_o(wiper_o), .wip_i(wip)
);

// File: tb/tb_dpot_serial_if.sv
module tb_dpot_serial_if;
  localparam int WW = 7;
  localparam int PROG = 2000;
  localparam logic [7:0] IDW = 8'h52, IDR = 8'h53;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic addr = 1'b1;
  logic sdo, sdo_oe;
  logic [WW-1:0] wiper;
  int checks = 0, errors = 0;
  logic [7:0] rx;
  logic oe_seen;

  always #5 clk = ~clk;

  dpot_serial_if #(.WW(WW), .PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .addr_i(addr), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wiper_o(wiper)
  );

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] b0, b1, b2, b3, input int n);
    logic [7:0] bs [4];
    bs = '{b0, b1, b2, b3};
    rx = '0; oe_seen = 1'b0;
    cs_n = 1'b0; idle(8);
    for (int i = 0; i < n; i++) begin
      for (int k = 7; k >= 0; k--) begin
        sdi = bs[i][k];
        idle(8);
        oe_seen = oe_seen | sdo_oe;
        if (i == 3) rx[k] = sdo;
        sck = 1'b1; idle(8);
        sck = 1'b0;
      end
    end
    idle(8); cs_n = 1'b1; idle(16);
  endtask

  task automatic rd_status(output logic [7:0] v);
    xfer(IDR, 8'h40, 8'h00, 8'h00, 4); v = rx;
  endtask

  task automatic rd_dr(input int p, output logic [7:0] v);
    xfer(IDR, 8'hC0 | 8'(p << 2), 8'h00, 8'h00, 4); v = rx;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk(wiper, 0, "R1 wiper");
    chk(sdo_oe, 0, "R1 oe");
    rd_status(v); chk(v, 0, "R1/R9 status");
    rd_dr(3, v);  chk(v, 0, "R1 dr3");
  endtask

  task automatic t_wcr;
    xfer(IDW, 8'hA0, 8'h00, 8'h2A, 4); chk(wiper, 8'h2A, "R5 write wiper");
    xfer(IDW, 8'hA0, 8'h00, 8'hFF, 4); chk(wiper, 8'h7F, "R5 truncate to WW");
    xfer(IDR, 8'h80, 8'h00, 8'h00, 4);
    chk(rx, 8'h7F, "R6 read wiper"); chk(oe_seen, 1, "R6 oe during read");
  endtask

  task automatic t_dr_write;
    logic [7:0] v;
    xfer(IDW, 8'hE8, 8'h00, 8'h15, 4);
    rd_status(v); chk(v, 1, "R7/R9 busy set");
    xfer(IDW, 8'hA0, 8'h00, 8'h11, 4); chk(wiper, 8'h7F, "R10 write dropped while busy");
    idle(PROG);
    rd_status(v); chk(v, 0, "R9 busy cleared");
    rd_dr(2, v);  chk(v, 8'h15, "R7 dr2 value");
    rd_dr(1, v);  chk(v, 0, "R3 pointer selects dr2 only");
  endtask

  task automatic t_moves;
    logic [7:0] v;
    xfer(IDW, 8'h68, 8'h00, 8'h00, 2); chk(wiper, 8'h15, "R8 dr2 to wiper");
    xfer(IDW, 8'hA0, 8'h00, 8'h07, 4);
    xfer(IDW, 8'h24, 8'h00, 8'h00, 2);
    rd_status(v); chk(v, 1, "R8 busy after wiper to dr");
    idle(PROG);
    rd_dr(1, v); chk(v, 8'h07, "R8 dr1 value");
  endtask

  task automatic t_drops;
    logic [7:0] v;
    xfer(8'h62, 8'hA0, 8'h00, 8'h33, 4); chk(wiper, 8'h07, "R2 bad type nibble");
    xfer(8'h50, 8'hA0, 8'h00, 8'h33, 4); chk(wiper, 8'h07, "R2 addr mismatch");
    xfer(8'h51, 8'h80, 8'h00, 8'h00, 4); chk(oe_seen, 0, "R2 no oe on mismatch");
    xfer(IDR, 8'hA0, 8'h00, 8'h33, 4);   chk(wiper, 8'h07, "R4 rw mismatch");
    xfer(IDW, 8'hB0, 8'h00, 8'h33, 4);   chk(wiper, 8'h07, "R3 reserved bit4");
    xfer(IDW, 8'h00, 8'h00, 8'h33, 4);   chk(wiper, 8'h07, "R3 opcode 000");
    xfer(IDW, 8'hEC, 8'h00, 8'h44, 3);
    rd_status(v); chk(v, 0, "R11 truncated no busy");
    rd_dr(3, v);  chk(v, 0, "R11 dr3 unchanged");
    xfer(IDW, 8'h6C, 8'h00, 8'h00, 1); chk(wiper, 8'h07, "R11 one-byte move");
  endtask

  initial begin
    idle(5); rst_n = 1'b1; idle(5);
    t_reset();
    t_wcr();
    t_dr_write();
    t_moves();
    t_drops();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule